// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block carries out one software-issued transaction on an external serial NOR flash over a single-line SPI bus. Software loads an opcode, a flash address, global and timing settings and, for writes, up to 64 bytes into a sixteen-word buffer. It then writes a command word whose bit 0 launches the frame. The sequencer lowers chip select and waits out a programmable setup time. It shifts out the opcode, optionally the address, then either sends buffer bytes or captures flash bytes into the buffer. It holds chip select for a programmable time, keeps chip select high for a minimum gap, and finally sets a sticky done flag.

The register port uses word offsets. Offset 0 is global: bit 0 selects Mode3, bit 1 enables write protect, bit 2 selects 4-byte addressing, and bits 5:3 hold the read delay. Offset 1 is timing: bits 3:0 set the gap value G, bits 6:4 the setup value S, and bits 10:8 the hold value H. Offset 2 holds the opcode, offset 3 the address, and offset 4 the command word: bit 0 start, bit 2 address enable, bit 7 data enable, bit 8 read (1) or write (0), bits 14:9 byte count minus one. Offset 5 is raw status, with bit 0 done and bit 1 busy. Offset 6 holds the done-interrupt enable (bit 0) and offset 7 the masked status (bit 0). Writing 1 to bit 0 of offset 8 clears done. Offsets 16 to 31 are buffer words 0 to 15. Register reads are combinational.

Top module: `flash_cmd_seq`

## Requirements
- R1: Writing offset 4 with bit 0 set while idle starts a frame. The same write while busy is ignored: the stored command fields and the frame on the bus stay unchanged.
- R2: The frame sends the 8-bit opcode MSB first. When bit 2 of the command is set, it then sends the address MSB first: the low 3 bytes, or all 4 bytes when global bit 2 is set. The number of serial clock rising edges is 8 times the number of bytes in the frame.
- R3: For a write with data enabled, count+1 bytes follow the address. Byte n comes from bits 8*(n mod 4)+7 down to 8*(n mod 4) of buffer word n/4, sent MSB first.
- R4: For a read, each captured byte n (first captured bit is the byte's MSB) is stored into the same lane of the same word. Buffer lanes beyond the count keep their prior value.
- R5: With read delay field value d (values 4 to 7 act as 3), the bit captured for a serial clock rising edge is the data input value present d system clocks after the first clock of that high half.
- R6: The serial clock idles at global bit 0 (0 for Mode0, 1 for Mode3) whenever chip select is high. Bits follow one another every 2 system clocks, with data out stable across each rising edge.
- R7: The first rising edge comes S+2 clocks after chip select falls. Chip select rises H+2 clocks after the last rising edge.
- R8: After chip select rises, done is raised max(G+2, 5) clocks later.
- R9: Done stays set until bit 0 of offset 8 is written with 1. The masked status and the irq output equal done AND the enable bit.
- R10: The active-low write-protect output is low exactly while global bit 1 is set.
- R11: Status bit 1 reads 1 from the start write until done is raised, and 0 afterwards.
- R12: After reset, chip select is high, the serial clock is low, write protect is inactive, and raw status and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register word offset |
| regWdata | input | 32 | Register write data |
| regWe | input | 1 | Register write strobe |
| regRdata | output | 32 | Register read data at regAddr |
| irq | output | 1 | Done AND enable |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSclk | output | 1 | Serial clock |
| flashMosi | output | 1 | Serial data to flash |
| flashMiso | input | 1 | Serial data from flash |
| flashWpN | output | 1 | Write protect, active low |

## Verification
The bench builds the block with its default parameters: sixteen buffer words and a 5-clock gap floor. This makes full 64-byte transfers reachable, as well as transfers that end part-way through a word and leave other lanes untouched. The 4-bit gap field spans values below and above the floor, so both the clamped gap and the programmed gap are exercised. The 3-bit read-delay field covers every capture offset, including the values that clamp to the largest.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int BUF_WORDS  = 16;
  localparam int WORD_W     = 32;
  localparam int BYTE_IDX_W = $clog2(BUF_WORDS * WORD_W / 8);
  localparam int WIDX_W     = $clog2(BUF_WORDS);
  localparam int REG_AW     = WIDX_W + 1;

  localparam logic [REG_AW-1:0] OFS_GLOBAL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_TIMING = REG_AW'(1);
  localparam logic [REG_AW-1:0] OFS_OPCODE = REG_AW'(2);
  localparam logic [REG_AW-1:0] OFS_ADDR   = REG_AW'(3);
  localparam logic [REG_AW-1:0] OFS_CMD    = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFS_RAW    = REG_AW'(5);
  localparam logic [REG_AW-1:0] OFS_IRQEN  = REG_AW'(6);
  localparam logic [REG_AW-1:0] OFS_MASKED = REG_AW'(7);
  localparam logic [REG_AW-1:0] OFS_CLEAR  = REG_AW'(8);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_OPC, ST_ADDR, ST_DATA, ST_HOLD, ST_GAP
  } seqState_e;

  typedef enum logic [1:0] { SRC_OPC, SRC_ADDR, SRC_DATA } byteSrc_e;

  typedef struct packed {
    logic                  loadByte;
    byteSrc_e              src;
    logic [BYTE_IDX_W-1:0] idx;
    logic                  rxPhase;
    logic                  clrRx;
  } seqStrobe_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int GAP_MIN = 5,
  parameter int TMR_W   = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  clrDone,
  input  logic                  addrEn,
  input  logic                  dataEn,
  input  logic                  rdMode,
  input  logic [BYTE_IDX_W-1:0] byteCntM1,
  input  logic                  addr4,
  input  logic [2:0]            tcss,
  input  logic [2:0]            tcsh,
  input  logic [3:0]            tshsl,
  input  logic                  byteEnd,
  output seqStrobe_t            stb,
  output logic                  csN,
  output logic                  busy,
  output logic                  doneRaw
);
  seqState_e             state, nState;
  logic [TMR_W-1:0]      tmr, nTmr;
  logic [BYTE_IDX_W-1:0] cnt, nCnt;
  logic                  setDone;
  logic [1:0]            addrBase, addrIdx;
  logic [TMR_W-1:0]      gapRaw, gapLen;

  assign addrBase = addr4 ? 2'd0 : 2'd1;
  assign addrIdx  = addrBase + cnt[1:0];
  assign gapRaw   = TMR_W'(tshsl) + TMR_W'(2);
  assign gapLen   = (gapRaw < TMR_W'(GAP_MIN)) ? TMR_W'(GAP_MIN) : gapRaw;

  always_comb begin
    nState      = state;
    nTmr        = tmr;
    nCnt        = cnt;
    setDone     = 1'b0;
    stb         = '0;
    stb.src     = SRC_OPC;
    stb.rxPhase = (state == ST_DATA) && rdMode;
    unique case (state)
      ST_IDLE: if (startReq) begin
        nState    = ST_SETUP;
        nTmr      = TMR_W'(tcss);
        stb.clrRx = 1'b1;
      end
      ST_SETUP: if (tmr == '0) begin
        nState       = ST_OPC;
        stb.loadByte = 1'b1;
        stb.src      = SRC_OPC;
      end else nTmr = tmr - 1'b1;
      ST_OPC, ST_ADDR: if (byteEnd) begin
        if (state == ST_OPC && addrEn) begin
          nState       = ST_ADDR;
          nCnt         = '0;
          stb.loadByte = 1'b1;
          stb.src      = SRC_ADDR;
          stb.idx      = BYTE_IDX_W'(addrBase);
        end else if (state == ST_ADDR && addrIdx != 2'd3) begin
          nCnt         = cnt + 1'b1;
          stb.loadByte = 1'b1;
          stb.src      = SRC_ADDR;
          stb.idx      = BYTE_IDX_W'(addrIdx + 2'd1);
        end else if (dataEn) begin
          nState       = ST_DATA;
          nCnt         = '0;
          stb.loadByte = 1'b1;
          stb.src      = SRC_DATA;
          stb.idx      = '0;
        end else begin
          nState = ST_HOLD;
          nTmr   = TMR_W'(tcsh);
        end
      end
      ST_DATA: if (byteEnd) begin
        if (cnt == byteCntM1) begin
          nState = ST_HOLD;
          nTmr   = TMR_W'(tcsh);
        end else begin
          nCnt         = cnt + 1'b1;
          stb.loadByte = 1'b1;
          stb.src      = SRC_DATA;
          stb.idx      = cnt + 1'b1;
        end
      end
      ST_HOLD: if (tmr == '0) begin
        nState = ST_GAP;
        nTmr   = gapLen - 1'b1;
      end else nTmr = tmr - 1'b1;
      ST_GAP: if (tmr == '0) begin
        nState  = ST_IDLE;
        setDone = 1'b1;
      end else nTmr = tmr - 1'b1;
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      cnt     <= '0;
      doneRaw <= 1'b0;
    end else begin
      state <= nState;
      tmr   <= nTmr;
      cnt   <= nCnt;
      if (setDone)      doneRaw <= 1'b1;
      else if (clrDone) doneRaw <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = !(state inside {ST_SETUP, ST_OPC, ST_ADDR, ST_DATA, ST_HOLD});

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneRaw && !clrDone) |=> doneRaw);
  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrDone && state != ST_GAP) |=> !doneRaw);
  assert_gap_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneRaw) |-> (csN && $past(csN, 1) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4)));
endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [WORD_W-1:0]     regWdata,
  input  logic                  regWe,
  output logic [WORD_W-1:0]     regRdata,
  input  logic                  busy,
  input  logic                  doneRaw,
  input  seqStrobe_t            stb,
  output logic                  startReq,
  output logic                  clrDone,
  output logic                  addrEn,
  output logic                  dataEn,
  output logic                  rdMode,
  output logic [BYTE_IDX_W-1:0] byteCntM1,
  output logic                  addr4,
  output logic [2:0]            tcss,
  output logic [2:0]            tcsh,
  output logic [3:0]            tshsl,
  output logic                  byteEnd,
  output logic                  irq,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  wpN
);
  logic              gMode3, gWp;
  logic [2:0]        gRdDly;
  logic [7:0]        opcode;
  logic [WORD_W-1:0] addrReg;
  logic              irqEn;
  logic [WORD_W-1:0] dataBuf [BUF_WORDS];

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gMode3 <= 1'b0; gWp <= 1'b0; addr4 <= 1'b0; gRdDly <= '0;
      tshsl <= '0; tcss <= '0; tcsh <= '0;
      opcode <= '0; addrReg <= '0; irqEn <= 1'b0;
      addrEn <= 1'b0; dataEn <= 1'b0; rdMode <= 1'b0; byteCntM1 <= '0;
    end else if (regWe) begin
      unique case (regAddr)
        OFS_GLOBAL: {gRdDly, addr4, gWp, gMode3} <= regWdata[5:0];
        OFS_TIMING: begin
          tshsl <= regWdata[3:0];
          tcss  <= regWdata[6:4];
          tcsh  <= regWdata[10:8];
        end
        OFS_OPCODE: opcode  <= regWdata[7:0];
        OFS_ADDR:   addrReg <= regWdata;
        OFS_CMD: if (!busy) begin
          addrEn    <= regWdata[2];
          dataEn    <= regWdata[7];
          rdMode    <= regWdata[8];
          byteCntM1 <= regWdata[9 +: BYTE_IDX_W];
        end
        OFS_IRQEN:  irqEn <= regWdata[0];
        default: ;
      endcase
    end
  end

  assign startReq = regWe && (regAddr == OFS_CMD) && regWdata[0];
  assign clrDone  = regWe && (regAddr == OFS_CLEAR) && regWdata[0];
  assign irq      = doneRaw && irqEn;
  assign wpN      = !gWp;

  always_comb begin
    regRdata = '0;
    if (regAddr[REG_AW-1]) regRdata = dataBuf[regAddr[WIDX_W-1:0]];
    else begin
      unique case (regAddr)
        OFS_GLOBAL: regRdata = WORD_W'({gRdDly, addr4, gWp, gMode3});
        OFS_TIMING: regRdata = WORD_W'({tcsh, 1'b0, tcss, tshsl});
        OFS_OPCODE: regRdata = WORD_W'(opcode);
        OFS_ADDR:   regRdata = addrReg;
        OFS_CMD:    regRdata = WORD_W'({byteCntM1, rdMode, dataEn, 4'b0, addrEn, 2'b0});
        OFS_RAW:    regRdata = WORD_W'({busy, doneRaw});
        OFS_IRQEN:  regRdata = WORD_W'(irqEn);
        OFS_MASKED: regRdata = WORD_W'(doneRaw && irqEn);
        default:    regRdata = '0;
      endcase
    end
  end

  // transmit bit engine: two system clocks per serial bit
  logic       active, ph;
  logic [2:0] bitCnt;
  logic [7:0] txSh, selByte;
  logic [4:0] laneSh;

  always_comb begin
    selByte = '0;
    laneSh  = '0;
    unique case (stb.src)
      SRC_OPC:  selByte = opcode;
      SRC_ADDR: begin
        laneSh  = {~stb.idx[1:0], 3'b000};
        selByte = addrReg[laneSh +: 8];
      end
      SRC_DATA: begin
        laneSh  = {stb.idx[1:0], 3'b000};
        selByte = rdMode ? 8'h00 : dataBuf[stb.idx[BYTE_IDX_W-1:2]][laneSh +: 8];
      end
      default: selByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; ph <= 1'b0; bitCnt <= '0; txSh <= '0;
    end else if (stb.loadByte) begin
      active <= 1'b1; ph <= 1'b0; bitCnt <= '0; txSh <= selByte;
    end else if (active) begin
      if (!ph) ph <= 1'b1;
      else begin
        ph     <= 1'b0;
        txSh   <= {txSh[6:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == 3'd7) active <= 1'b0;
      end
    end
  end

  assign byteEnd = active && ph && (bitCnt == 3'd7);
  assign sclk    = active ? ph : gMode3;
  assign mosi    = active && txSh[7];

  // receive path with delayed capture strobe
  logic                  sampleReq, capture;
  logic [2:0]            dlyLine;
  logic [1:0]            delSel;
  logic [6:0]            rxSh;
  logic [2:0]            rxBit;
  logic [BYTE_IDX_W-1:0] rxIdx;
  logic                  rxWrite;
  logic [7:0]            rxByte;
  logic [4:0]            rxLane;

  assign sampleReq = active && ph && stb.rxPhase;
  assign delSel    = (gRdDly > 3'd3) ? 2'd3 : gRdDly[1:0];
  assign capture   = (delSel == 2'd0) ? sampleReq : dlyLine[delSel - 2'd1];
  assign rxByte    = {rxSh, miso};
  assign rxWrite   = capture && (rxBit == 3'd7);
  assign rxLane    = {rxIdx[1:0], 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyLine <= '0; rxSh <= '0; rxBit <= '0; rxIdx <= '0;
    end else if (stb.clrRx) begin
      dlyLine <= '0; rxBit <= '0; rxIdx <= '0;
    end else begin
      dlyLine <= {dlyLine[1:0], sampleReq};
      if (capture) begin
        rxSh  <= rxByte[6:0];
        rxBit <= rxBit + 1'b1;
        if (rxBit == 3'd7) rxIdx <= rxIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_WORDS; i++) dataBuf[i] <= '0;
    end else begin
      if (regWe && regAddr[REG_AW-1]) dataBuf[regAddr[WIDX_W-1:0]] <= regWdata;
      if (rxWrite) dataBuf[rxIdx[BYTE_IDX_W-1:2]][rxLane +: 8] <= rxByte;
    end
  end

  assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !ph) |=> $stable(mosi));
  assert_cfg_locked_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(byteCntM1) && $stable(rdMode) && $stable(dataEn) && $stable(addrEn)));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int GAP_MIN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              regWe,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq,
  output logic              flashCsN,
  output logic              flashSclk,
  output logic              flashMosi,
  input  logic              flashMiso,
  output logic              flashWpN
);
  localparam int TMR_W = $clog2(GAP_MIN + 18);

  seqStrobe_t            stb;
  logic                  startReq, clrDone, addrEn, dataEn, rdMode, addr4;
  logic                  byteEnd, busy, doneRaw;
  logic [BYTE_IDX_W-1:0] byteCntM1;
  logic [2:0]            tcss, tcsh;
  logic [3:0]            tshsl;

  flash_seq_ctrl #(.GAP_MIN(GAP_MIN), .TMR_W(TMR_W)) i_ctrl (
    .clk, .rstN, .startReq, .clrDone, .addrEn, .dataEn, .rdMode, .byteCntM1,
    .addr4, .tcss, .tcsh, .tshsl, .byteEnd, .stb, .csN(flashCsN), .busy, .doneRaw
  );

  flash_seq_datapath i_dp (
    .clk, .rstN, .regAddr, .regWdata, .regWe, .regRdata, .busy, .doneRaw, .stb,
    .startReq, .clrDone, .addrEn, .dataEn, .rdMode, .byteCntM1, .addr4, .tcss,
    .tcsh, .tshsl, .byteEnd, .irq, .sclk(flashSclk), .mosi(flashMosi),
    .miso(flashMiso), .wpN(flashWpN)
  );

  assert_cs_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flashCsN && !$past(regWe)) |-> (flashSclk == $past(flashSclk)));
  assert_cs_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    !flashCsN |-> busy);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  import flash_seq_pkg::*;

  logic clk = 1'b0, rstN = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic regWe = 1'b0, flashMiso = 1'b0;
  logic [31:0] regRdata;
  logic irq, flashCsN, flashSclk, flashMosi, flashWpN;

  always #2.5 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk, .rstN, .regAddr, .regWdata, .regWe, .regRdata, .irq,
    .flashCsN, .flashSclk, .flashMosi, .flashMiso, .flashWpN
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pat(int k);
    int unsigned h = k * 32'h9E3779B1;
    return h[17] ^ h[23];
  endfunction

  always @(negedge clk) flashMiso <= pat(cyc);

  // bus monitor
  logic prevCs = 1'b1, prevSclk = 1'b0, prevIrq = 1'b0;
  int frameStart = 0, riseN = 0, csRiseCyc = 0, doneCyc = 0, periodErr = 0, idleErr = 0;
  int riseCyc [600];
  logic txBit [600];
  bit idleChk = 0;
  logic expIdle = 1'b0;

  always @(negedge clk) begin
    if (!flashCsN && prevCs) begin frameStart = cyc; riseN = 0; periodErr = 0; end
    if (!flashCsN && flashSclk && !prevSclk) begin
      if (riseN > 0 && riseN < 600 && cyc - riseCyc[riseN-1] != 2) periodErr++;
      if (riseN < 600) begin riseCyc[riseN] = cyc; txBit[riseN] = flashMosi; end
      riseN++;
    end
    if (flashCsN && !prevCs) csRiseCyc = cyc;
    if (irq && !prevIrq) doneCyc = cyc;
    if (flashCsN && idleChk && flashSclk !== expIdle) idleErr++;
    prevCs = flashCsN; prevSclk = flashSclk; prevIrq = irq;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(int a, logic [31:0] d);
    @(negedge clk);
    regAddr = REG_AW'(a); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = REG_AW'(a);
    #1 d = regRdata;
  endtask

  logic [31:0] bufModel [16];

  task automatic runOp(logic [7:0] opc, logic [31:0] addr, bit aEn, bit dEn, bit rd,
                       int cntM1, bit m3, bit a4, int dly, int tcss, int tcsh,
                       int tshsl, bit wp, bit poke);
    logic [31:0] cmd, rv, expW;
    int nA, nD, d, base, gap, errs, n;
    logic [7:0] got;
    idleChk = 0;
    regWrite(0, {26'b0, 3'(dly), a4, wp, m3});
    expIdle = m3;
    idleErr = 0;
    idleChk = 1;
    chk("R10", "write protect pin", flashWpN, !wp);
    regWrite(1, {21'b0, 3'(tcsh), 1'b0, 3'(tcss), 4'(tshsl)});
    regWrite(2, {24'b0, opc});
    regWrite(3, addr);
    regWrite(6, 32'h1);
    for (int w = 0; w < 16; w++) begin
      bufModel[w] = $urandom;
      regWrite(16 + w, bufModel[w]);
    end
    cmd = (32'(cntM1) << 9) | (32'(rd) << 8) | (32'(dEn) << 7) | (32'(aEn) << 2) | 32'h1;
    regWrite(4, cmd);
    regRead(5, rv);
    chk("R11", "busy right after start", rv[1], 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      regWrite(4, 32'h1 | (32'd3 << 9) | (32'd1 << 7));
      regRead(4, rv);
      chk("R1", "command fields after start while busy", rv, cmd & ~32'h1);
    end
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    #1;
    chk("R9", "irq raised at end", irq, 1);
    nA = aEn ? (a4 ? 4 : 3) : 0;
    nD = dEn ? cntM1 + 1 : 0;
    chk("R2", "rising edge count", riseN, 8 * (1 + nA + nD));
    got = '0;
    for (int j = 0; j < 8; j++) got = {got[6:0], txBit[j]};
    chk("R2", "opcode bits", got, opc);
    if (aEn) begin
      rv = '0;
      for (int j = 0; j < 8 * nA; j++) rv = {rv[30:0], txBit[8 + j]};
      chk("R2", "address bits", rv, a4 ? addr : {8'b0, addr[23:0]});
    end
    base = 8 * (1 + nA);
    d = (dly > 3) ? 3 : dly;
    if (dEn && !rd) begin
      errs = 0;
      for (int b = 0; b < nD; b++) begin
        for (int j = 0; j < 8; j++) got = {got[6:0], txBit[base + 8 * b + j]};
        if (got != bufModel[b / 4][8 * (b % 4) +: 8]) errs++;
      end
      chk("R3", "write bytes mismatched", errs, 0);
    end
    if (dEn && rd) begin
      for (int w = 0; w < 16; w++) begin
        expW = bufModel[w];
        for (int l = 0; l < 4; l++) begin
          if (4 * w + l < nD) begin
            for (int j = 0; j < 8; j++)
              expW[8 * l + 7 - j] = pat(riseCyc[base + 8 * (4 * w + l) + j] + d);
          end
        end
        regRead(16 + w, rv);
        chk("R4 R5", "read buffer word", rv, expW);
      end
    end
    chk("R7", "setup to first rise", riseCyc[0] - frameStart, tcss + 2);
    chk("R7", "last rise to deselect", csRiseCyc - riseCyc[riseN - 1], tcsh + 2);
    gap = (tshsl + 2 < 5) ? 5 : tshsl + 2;
    chk("R8", "deselect gap", doneCyc - csRiseCyc, gap);
    chk("R6", "bit period errors", periodErr, 0);
    chk("R6", "idle level errors", idleErr, 0);
    regRead(5, rv);
    chk("R9 R11", "raw status at end", rv, 32'h1);
    regRead(7, rv);
    chk("R9", "masked status", rv, 32'h1);
    regWrite(8, 32'h1);
    regRead(5, rv);
    chk("R9", "raw status after clear", rv, 32'h0);
    chk("R9", "irq after clear", irq, 0);
    idleChk = 0;
  endtask

  initial begin
    #(180000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int unsigned seedInit;
    seedInit = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    regRead(5, rv);
    chk("R12", "raw status after reset", rv, 0);
    chk("R12", "chip select after reset", flashCsN, 1);
    chk("R12", "serial clock after reset", flashSclk, 0);
    chk("R12", "write protect after reset", flashWpN, 1);
    chk("R12", "irq after reset", irq, 0);

    // directed corners
    runOp(8'h9F, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    runOp(8'hD8, 32'hA5_12_34_56, 1, 0, 0, 0, 1, 0, 0, 2, 1, 4, 1, 0);
    runOp(8'h12, 32'h8765_4321, 1, 1, 0, 63, 0, 1, 0, 7, 7, 15, 0, 0);
    runOp(8'h02, 32'h0000_0100, 1, 1, 0, 0, 1, 0, 0, 1, 3, 3, 0, 0);
    for (int dl = 0; dl < 8; dl++)
      runOp(8'h03, 32'h00_0F_00_F0 + 32'(dl), 1, 1, 1, 4 + dl, dl[0], dl[1], dl, 0, 1, 2, 0, 0);
    runOp(8'h0B, 32'h0012_3456, 1, 1, 1, 63, 1, 1, 2, 3, 2, 6, 1, 0);
    runOp(8'h02, 32'h0000_2000, 1, 1, 0, 20, 0, 0, 0, 1, 1, 1, 0, 1);

    // mask behaviour (R9)
    regWrite(6, 32'h0);
    regWrite(4, 32'h1);
    repeat (60) @(negedge clk);
    regRead(5, rv);
    chk("R9", "raw done with mask off", rv, 32'h1);
    regRead(7, rv);
    chk("R9", "masked status with mask off", rv, 32'h0);
    chk("R9", "irq with mask off", irq, 0);
    regWrite(6, 32'h1);
    regRead(7, rv);
    chk("R9", "masked status with mask on", rv, 32'h1);
    chk("R9", "irq with mask on", irq, 1);
    regWrite(8, 32'h1);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      runOp(8'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(63, 0)), 1'($urandom), 1'($urandom),
            int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
            int'($urandom_range(7, 0)), int'($urandom_range(15, 0)),
            1'($urandom), (it % 6) == 5);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule